// File: doc/BRIEF.md
# Double to Unsigned Integer Converter

This block takes one IEEE 754 double-precision operand and turns it into an unsigned integer. A size select picks the result width: a full 64-bit result, or a 32-bit result placed zero-extended in the 64-bit output. When the operand is not a whole number, the block rounds it using one of four modes. That mode comes from a per-operation rounding field only when an override enable is set and the operand was read from a register. In every other case the mode comes from a global rounding control field.

Each conversion gives an integer result and two exception flags. The invalid flag is raised for NaNs, infinities and any value whose rounded result falls outside 0 to 2^w − 1. An invalid conversion returns the all-ones pattern for the chosen width. The inexact flag is raised when rounding discarded a nonzero fraction. The block is a single registered pipeline stage with no backpressure: a valid input gives a valid output exactly one clock later.

Top module: `dbl_to_uint_cvt`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise; a synchronous active-high `rst` clears `out_valid`.
- R2: With `in_wide` = 1 the result is a 64-bit unsigned value; with `in_wide` = 0 it is a 32-bit unsigned value and `out_result[63:32]` is zero.
- R3: The rounding mode is `in_rc_field` when both `in_rc_ovr` and `in_src_reg` are 1, and `ctl_rc` otherwise; the encoding is 2'b00 nearest-even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, 2'b11 toward zero.
- R4: A finite in-range value with a nonzero fraction is rounded in the selected mode and raises `out_inexact`.
- R5: A value that is already a whole number in range converts exactly, with both flags low.
- R6: A finite value that rounds above 2^w − 1 raises `out_invalid` and returns 2^w − 1, zero-extended to 64 bits when w = 32.
- R7: NaN inputs (quiet and signalling) and both infinities raise `out_invalid` and return 2^w − 1.
- R8: A negative value that rounds to zero returns 0 and raises `out_inexact`; a negative value that rounds to a magnitude of 1 or more is invalid; negative zero returns 0 with no flags.
- R9: A denormal input returns 0 or 1 depending on the mode and raises `out_inexact` (a negative denormal rounded toward negative infinity is invalid).
- R10: `out_invalid` and `out_inexact` are never high together; invalid wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Double-precision operand |
| in_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_rc_ovr | input | 1 | Per-operation rounding override enable |
| in_src_reg | input | 1 | Operand was read from a register |
| in_rc_field | input | 2 | Per-operation rounding mode |
| ctl_rc | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Unsigned integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision (inexact) flag |

## Verification
The assertions assume that `in_valid` and the operand fields are known whenever reset is low. They also treat the output fields as meaningful only while `out_valid` is high. The stimulus therefore drives every input to a defined value from time zero and changes inputs only between clock edges. The sweeps cover every quarter-step value from −10 to +10, in all four modes, at both widths, and through all three rounding-source routes. Directed operands then probe the 2^32 and 2^64 boundaries, the special encodings and the denormal range.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

endpackage

// File: rtl/cvt_rm_sel.sv
module cvt_rm_sel
  import cvt_pkg::*;
(
  input  logic       ovr_en,
  input  logic       src_reg,
  input  logic [1:0] op_field,
  input  logic [1:0] glb_field,
  output rmode_e     mode
);

  always_comb begin
    if (ovr_en && src_reg) mode = rmode_e'(op_field);
    else                   mode = rmode_e'(glb_field);
  end

endmodule

// File: rtl/cvt_classify.sv
module cvt_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int MAN_W = FRAC_W + 1,
  localparam int UE_W  = EXP_W + 2
) (
  input  logic [OP_W-1:0]        operand,
  output logic                   sign,
  output logic                   nan_inf,
  output logic [MAN_W-1:0]       mant,
  output logic signed [UE_W-1:0] uexp
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;

  always_comb begin
    sign     = operand[OP_W-1];
    exp_f    = operand[OP_W-2:FRAC_W];
    frac_f   = operand[FRAC_W-1:0];
    exp_zero = (exp_f == '0);
    nan_inf  = (exp_f == '1);
    mant     = {~exp_zero, frac_f};
    if (exp_zero)
      uexp = $signed(UE_W'(1)) - $signed(UE_W'(BIAS));
    else
      uexp = $signed({2'b00, exp_f}) - $signed(UE_W'(BIAS));
  end

endmodule

// File: rtl/cvt_align.sv
module cvt_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RES_W  = 64,
  localparam int MAN_W = FRAC_W + 1,
  localparam int UE_W  = EXP_W + 2
) (
  input  logic [MAN_W-1:0]       mant,
  input  logic signed [UE_W-1:0] uexp,
  output logic [RES_W-1:0]       int_mag,
  output logic                   rbit,
  output logic                   sticky,
  output logic                   too_big
);

  logic [2*MAN_W-1:0] rshift;
  logic [UE_W-1:0]    rsh_amt;
  logic [UE_W-1:0]    lsh_amt;

  always_comb begin
    rsh_amt = UE_W'(FRAC_W) - uexp;
    lsh_amt = uexp - UE_W'(FRAC_W);
    rshift  = {mant, {MAN_W{1'b0}}} >> rsh_amt;
    int_mag = '0;
    rbit    = 1'b0;
    sticky  = 1'b0;
    too_big = 1'b0;
    if (uexp < 0) begin
      // magnitude below one: only the half bit and the rest remain
      rbit   = (uexp == -1);
      sticky = (uexp == -1) ? |mant[MAN_W-2:0] : |mant;
    end else if (uexp <= $signed(UE_W'(FRAC_W))) begin
      int_mag = RES_W'(rshift[2*MAN_W-1:MAN_W]);
      rbit    = rshift[MAN_W-1];
      sticky  = |rshift[MAN_W-2:0];
    end else if (uexp < $signed(UE_W'(RES_W))) begin
      int_mag = RES_W'(mant) << lsh_amt;
    end else begin
      too_big = 1'b1;
    end
  end

endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
#(
  parameter int RES_W    = 64,
  parameter int NARROW_W = 32
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic             nan_inf,
  input  logic             wide,
  input  logic [RES_W-1:0] int_mag,
  input  logic             rbit,
  input  logic             sticky,
  input  logic             too_big,
  output logic [RES_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);

  logic             lost;
  logic             inc;
  logic [RES_W:0]   sum;
  logic             over;
  logic             neg_bad;
  logic [RES_W-1:0] sat;

  always_comb begin
    lost = rbit | sticky;
    unique case (mode)
      RM_NEAR: inc = rbit & (sticky | int_mag[0]);
      RM_DOWN: inc = sign & lost;
      RM_UP:   inc = ~sign & lost;
      default: inc = 1'b0;
    endcase
    sum     = {1'b0, int_mag} + {{RES_W{1'b0}}, inc};
    over    = too_big | (wide ? sum[RES_W] : |sum[RES_W:NARROW_W]);
    neg_bad = sign & (sum != '0);
    invalid = nan_inf | over | neg_bad;
    sat     = wide ? {RES_W{1'b1}} : {{(RES_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    if (invalid)   result = sat;
    else if (sign) result = '0;
    else           result = sum[RES_W-1:0];
    inexact = ~invalid & lost;
  end

endmodule

// File: rtl/dbl_to_uint_cvt.sv
module dbl_to_uint_cvt
  import cvt_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int OP_W    = 1 + EXP_W + FRAC_W,
  localparam int MAN_W   = FRAC_W + 1,
  localparam int UE_W    = EXP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_operand,
  input  logic              in_wide,
  input  logic              in_rc_ovr,
  input  logic              in_src_reg,
  input  logic [1:0]        in_rc_field,
  input  logic [1:0]        ctl_rc,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_inexact
);

  rmode_e                mode;
  logic                  sign;
  logic                  nan_inf;
  logic [MAN_W-1:0]      mant;
  logic signed [UE_W-1:0] uexp;
  logic [WIDE_W-1:0]     int_mag;
  logic                  rbit;
  logic                  sticky;
  logic                  too_big;
  logic [WIDE_W-1:0]     res_d;
  logic                  inv_d;
  logic                  inx_d;
  logic                  wide_q;
  logic                  sign_q;

  cvt_rm_sel u_rm_sel (
    .ovr_en    (in_rc_ovr),
    .src_reg   (in_src_reg),
    .op_field  (in_rc_field),
    .glb_field (ctl_rc),
    .mode      (mode)
  );

  cvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .operand (in_operand),
    .sign    (sign),
    .nan_inf (nan_inf),
    .mant    (mant),
    .uexp    (uexp)
  );

  cvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(WIDE_W)) u_align (
    .mant    (mant),
    .uexp    (uexp),
    .int_mag (int_mag),
    .rbit    (rbit),
    .sticky  (sticky),
    .too_big (too_big)
  );

  cvt_round #(.RES_W(WIDE_W), .NARROW_W(NARROW_W)) u_round (
    .mode    (mode),
    .sign    (sign),
    .nan_inf (nan_inf),
    .wide    (in_wide),
    .int_mag (int_mag),
    .rbit    (rbit),
    .sticky  (sticky),
    .too_big (too_big),
    .result  (res_d),
    .invalid (inv_d),
    .inexact (inx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      wide_q      <= 1'b0;
      sign_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_d;
        out_invalid <= inv_d;
        out_inexact <= inx_d;
        wide_q      <= in_wide;
        sign_q      <= sign;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q) |-> (out_result[WIDE_W-1:NARROW_W] == '0)); // R2
  AST_INVALID_SAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid && wide_q) |-> (out_result == {WIDE_W{1'b1}})); // R6
  AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sign_q && !out_invalid) |-> (out_result == '0)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_invalid && out_inexact)); // R10

endmodule

// File: tb/tb_dbl_to_uint_cvt.sv
`timescale 1ns/1ps
module tb_dbl_to_uint_cvt;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        in_wide = 1'b0;
  logic        in_rc_ovr = 1'b0;
  logic        in_src_reg = 1'b0;
  logic [1:0]  in_rc_field = 2'b00;
  logic [1:0]  ctl_rc = 2'b00;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] SAT32 = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] SAT64 = 64'hFFFF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  dbl_to_uint_cvt dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_wide(in_wide), .in_rc_ovr(in_rc_ovr), .in_src_reg(in_src_reg),
    .in_rc_field(in_rc_field), .ctl_rc(ctl_rc), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic conv(input logic [63:0] op, input logic wide, input logic ovr,
                      input logic src, input logic [1:0] fld, input logic [1:0] glb,
                      input logic [63:0] e_res, input logic e_inv, input logic e_inx,
                      input string tag);
    @(negedge clk);
    in_operand = op; in_wide = wide; in_rc_ovr = ovr; in_src_reg = src;
    in_rc_field = fld; ctl_rc = glb; in_valid = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b1 || out_result !== e_res || out_invalid !== e_inv ||
        out_inexact !== e_inx) begin
      errors++;
      $display("FAIL %s op=%h wide=%0d: got v=%0b res=%h inv=%0b inx=%0b exp res=%h inv=%0b inx=%0b",
               tag, op, wide, out_valid, out_result, out_invalid, out_inexact,
               e_res, e_inv, e_inx);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got out_valid=%0b exp 0", out_valid);
    end
  endtask

  // value n/4 rounded in mode m at width 64 or 32
  task automatic quarter_ref(input int n, input int m, input bit wide,
                             output logic [63:0] res, output logic inv, output logic inx);
    bit s; int a, ip, fr, inc, r;
    s = (n < 0); a = s ? -n : n; ip = a / 4; fr = a % 4;
    case (m)
      0: inc = (fr > 2 || (fr == 2 && (ip % 2) == 1)) ? 1 : 0;
      1: inc = (s && fr != 0) ? 1 : 0;
      2: inc = (!s && fr != 0) ? 1 : 0;
      default: inc = 0;
    endcase
    r = ip + inc;
    if (s && r != 0) begin
      inv = 1'b1; inx = 1'b0; res = wide ? SAT64 : SAT32;
    end else begin
      inv = 1'b0; inx = (fr != 0); res = s ? 64'd0 : 64'(r);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] e_res;
    logic e_inv, e_inx;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got out_valid=%0b exp 0", out_valid);
    end
    @(negedge clk); rst = 1'b0;
    idle_check();

    // R3 R4 R5 R8 sweep: quarter steps, all modes, both widths, three routes
    for (int n = -40; n <= 40; n++) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 2; w++) begin
          for (int rt = 0; rt < 3; rt++) begin
            logic [1:0] md, other;
            md = 2'(m); other = ~md;
            quarter_ref(n, m, w[0], e_res, e_inv, e_inx);
            case (rt)
              0: conv($realtobits(real'(n) / 4.0), w[0], 1'b1, 1'b1, md, other,
                      e_res, e_inv, e_inx, "R3 R4 R5 R8 sweep override");
              1: conv($realtobits(real'(n) / 4.0), w[0], 1'b1, 1'b0, other, md,
                      e_res, e_inv, e_inx, "R3 R4 R5 R8 sweep mem-source");
              default: conv($realtobits(real'(n) / 4.0), w[0], 1'b0, 1'b1, other, md,
                      e_res, e_inv, e_inx, "R3 R4 R5 R8 sweep no-override");
            endcase
          end
        end
      end
    end
    idle_check();

    // R3 route selection on 2.5
    conv($realtobits(2.5), 1'b1, 1'b1, 1'b0, 2'b10, 2'b00, 64'd2, 1'b0, 1'b1, "R3 field ignored mem");
    conv($realtobits(2.5), 1'b1, 1'b0, 1'b1, 2'b10, 2'b00, 64'd2, 1'b0, 1'b1, "R3 field ignored no-ovr");
    conv($realtobits(2.5), 1'b1, 1'b1, 1'b1, 2'b10, 2'b00, 64'd3, 1'b0, 1'b1, "R3 field used");

    // R6 R2 boundaries near 2^32 and 2^64
    conv($realtobits(4294967295.0), 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, SAT32, 1'b0, 1'b0, "R5 max narrow");
    conv($realtobits(4294967295.5), 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, SAT32, 1'b1, 1'b0, "R6 narrow rounds over");
    conv($realtobits(4294967295.5), 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, SAT32, 1'b0, 1'b1, "R4 narrow trunc");
    conv($realtobits(4294967295.5), 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 64'h1_0000_0000, 1'b0, 1'b1, "R2 wide near");
    conv($realtobits(4294967296.0), 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, SAT32, 1'b1, 1'b0, "R6 2^32 narrow");
    conv($realtobits(4294967296.0), 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 64'h1_0000_0000, 1'b0, 1'b0, "R2 2^32 wide");
    conv($realtobits(1099511627776.0), 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, SAT32, 1'b1, 1'b0, "R6 2^40 narrow");
    conv(64'h43EF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R5 top wide");
    conv(64'h43F0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, SAT64, 1'b1, 1'b0, "R6 2^64 wide");

    // R7 specials
    conv(64'h7FF0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, SAT64, 1'b1, 1'b0, "R7 +inf");
    conv(64'hFFF0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, SAT32, 1'b1, 1'b0, "R7 -inf");
    conv(64'h7FF8_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, SAT64, 1'b1, 1'b0, "R7 qnan");
    conv(64'h7FF0_0000_0000_0001, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, SAT32, 1'b1, 1'b0, "R7 snan");

    // R8 negative zero and negative one
    conv(64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 64'd0, 1'b0, 1'b0, "R8 neg zero");
    conv($realtobits(-1.0), 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, SAT32, 1'b1, 1'b0, "R8 minus one");

    // R9 denormals
    conv(64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 64'd0, 1'b0, 1'b1, "R9 denorm near");
    conv(64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 64'd0, 1'b0, 1'b1, "R9 denorm down");
    conv(64'h000F_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, 64'd1, 1'b0, 1'b1, "R9 denorm up");
    conv(64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 64'd0, 1'b0, 1'b1, "R9 denorm zero");
    conv(64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, SAT64, 1'b1, 1'b0, "R9 R10 neg denorm down");
    conv(64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 64'd0, 1'b0, 1'b1, "R9 neg denorm up");

    // R4 deep sticky bits
    conv(64'h3FF0_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 64'd2, 1'b0, 1'b1, "R4 1+ulp up");
    conv(64'h3FF0_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 64'd1, 1'b0, 1'b1, "R4 1+ulp zero");
    conv(64'h3FE0_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 64'd1, 1'b0, 1'b1, "R4 half+ulp near");
    conv(64'hBFE0_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, SAT64, 1'b1, 1'b0, "R8 R10 neg half+ulp");
    idle_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule